// File: doc/BRIEF.md
# Serial Field Memory with Lagging-Reader Protection

This block stores one video field as a sequence of 12-bit words and plays it back in the same order. Writes and reads each have their own sequential address pointer. A pointer moves on by one for every enabled access, and a restart strobe returns it to address zero. Both sides share one clock. Every write enable, and every read enable, is one word.

Written words do not reach the storage array at once. They pass through a delay line and land in the array a fixed number of cycles later. A reader may restart its pointer shortly after the writer has begun overwriting a field. Because of the delay, that reader still sees the complete previous field. A reader that restarts long enough after the writer sees the new field. Between those two distances the result is left unspecified, and users must avoid that spacing. Depth, commit delay and the guaranteed old-data distance are parameters, so a small instance can be used for simulation.

Top module: `smf_field_mem`

## Requirements
- R1: While reset is held and after its release, `rd_valid_o` is 0 and `rd_data_o` is 0 until the first read.
- R2: A cycle with `wr_rst_i` high writes (if `wr_en_i` is high) to address 0. Each later enabled write uses the next address, and the address wraps from DEPTH-1 to 0. Words are 12 bits.
- R3: A cycle with `rd_rst_i` high reads (if `rd_en_i` is high) from address 0, and later enabled reads step through the addresses with the same wrap. A restart cycle without `rd_en_i` produces no output and only rewinds the pointer.
- R4: Read data appears on `rd_data_o` one cycle after `rd_en_i`, with `rd_valid_o` high in exactly that cycle. In cycles after no read, `rd_valid_o` is 0 and `rd_data_o` keeps its last value.
- R5: A word written in cycle t is returned by a read issued in cycle t+COMMIT_LAT or later. A read issued at t+COMMIT_LAT-1 or earlier returns the previous content of that address.
- R6: If reader and writer both move one word per cycle and the read restart follows the write restart by OLD_WIN cycles or fewer, the whole previous field is read out.
- R7: Under the same lockstep, a read restart COMMIT_LAT or more cycles after the write restart reads out the field that was newly written.
- R8: In cycles where its enable and restart are both low, a pointer holds its value. Idle cycles between accesses therefore do not skip addresses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| wr_en_i | input | 1 | Write one word this cycle |
| wr_data_i | input | 12 | Word to write |
| wr_rst_i | input | 1 | Restart write pointer at address 0 |
| rd_en_i | input | 1 | Read one word this cycle |
| rd_rst_i | input | 1 | Restart read pointer at address 0 |
| rd_data_o | output | 12 | Registered read word |
| rd_valid_o | output | 1 | Read word valid |

## Verification
The hardest situation to create is a reader that restarts while a new field is still being written. Which field that reader sees depends on the exact cycle distance between the two restarts. The stimulus runs writer and reader from one loop that stays in lockstep, sweeping the restart distance over zero, OLD_WIN, COMMIT_LAT-1, COMMIT_LAT and a larger value. Between sweeps it idles long enough for every pending word to commit, so the expected old field is known exactly.

// File: rtl/smf_pkg.sv
package smf_pkg;
    localparam int unsigned WORD_W = 12;
    typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/smf_ptr.sv
module smf_ptr #(
    parameter int unsigned DEPTH = 256,
    localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          clr_i,
    input  logic          step_i,
    output logic [AW-1:0] addr_o,
    output logic [AW-1:0] ptr_o
);
    typedef struct packed {
        logic [AW-1:0] ptr;
    } ptr_state_t;

    ptr_state_t s_d, s_q;
    logic [AW-1:0] cur;

    always_comb begin
        s_d = s_q;
        cur = clr_i ? '0 : s_q.ptr;
        if (step_i) begin
            s_d.ptr = (cur == AW'(DEPTH - 1)) ? '0 : cur + 1'b1;
        end else begin
            s_d.ptr = cur;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign addr_o = cur;
    assign ptr_o  = s_q.ptr;
endmodule

// File: rtl/smf_commit_line.sv
module smf_commit_line
    import smf_pkg::*;
#(
    parameter int unsigned DEPTH      = 256,
    parameter int unsigned COMMIT_LAT = 600,
    localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned RING = COMMIT_LAT - 1,
    localparam int unsigned SW   = (RING > 1) ? $clog2(RING) : 1,
    localparam int unsigned EW   = AW + WORD_W
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          in_vld_i,
    input  logic [AW-1:0] in_addr_i,
    input  word_t         in_data_i,
    output logic          out_vld_o,
    output logic [AW-1:0] out_addr_o,
    output word_t         out_data_o
);
    // Each slot is revisited every RING cycles. Together with the array's
    // write edge, this makes the delay from write to visibility COMMIT_LAT.
    typedef struct packed {
        logic [SW-1:0]   slot;
        logic [RING-1:0] vld;
    } line_state_t;

    line_state_t s_d, s_q;
    logic [EW-1:0] ring_q [RING];

    always_comb begin
        s_d = s_q;
        s_d.vld[s_q.slot] = in_vld_i;
        s_d.slot = (s_q.slot == SW'(RING - 1)) ? '0 : s_q.slot + 1'b1;
        out_vld_o = s_q.vld[s_q.slot];
        {out_addr_o, out_data_o} = ring_q[s_q.slot];
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    always_ff @(posedge clk_i) begin
        ring_q[s_q.slot] <= {in_addr_i, in_data_i};
    end
endmodule

// File: rtl/smf_store.sv
module smf_store
    import smf_pkg::*;
#(
    parameter int unsigned DEPTH = 256,
    localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          we_i,
    input  logic [AW-1:0] waddr_i,
    input  word_t         wdata_i,
    input  logic          re_i,
    input  logic [AW-1:0] raddr_i,
    output word_t         rdata_o,
    output logic          rvld_o
);
    typedef struct packed {
        word_t data;
        logic  vld;
    } rd_state_t;

    rd_state_t s_d, s_q;
    word_t mem [DEPTH];

    // A commit and a read at the same address on the same edge return
    // the content from before the commit.
    always_comb begin
        s_d = s_q;
        s_d.vld = re_i;
        if (re_i) s_d.data = mem[raddr_i];
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    always_ff @(posedge clk_i) begin
        if (we_i) mem[waddr_i] <= wdata_i;
    end

    assign rdata_o = s_q.data;
    assign rvld_o  = s_q.vld;
endmodule

// File: rtl/smf_field_mem.sv
module smf_field_mem
    import smf_pkg::*;
#(
    parameter int unsigned DEPTH      = 256,
    parameter int unsigned COMMIT_LAT = 600,
    parameter int unsigned OLD_WIN    = 70,
    localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic        wr_en_i,
    input  logic [11:0] wr_data_i,
    input  logic        wr_rst_i,
    input  logic        rd_en_i,
    input  logic        rd_rst_i,
    output logic [11:0] rd_data_o,
    output logic        rd_valid_o
);
    logic [AW-1:0] wr_addr, wr_ptr_q, rd_addr, rd_ptr_q;
    logic          cm_vld;
    logic [AW-1:0] cm_addr;
    word_t         cm_data;

    if (COMMIT_LAT < 3 || OLD_WIN + 1 >= COMMIT_LAT || DEPTH < 2) begin : g_bad_cfg
        $error("smf_field_mem: need DEPTH>=2, COMMIT_LAT>=3, OLD_WIN<COMMIT_LAT-1");
    end

    smf_ptr #(.DEPTH(DEPTH)) u_wr_ptr (
        .clk_i (clk_i), .rst_ni(rst_ni),
        .clr_i (wr_rst_i), .step_i(wr_en_i),
        .addr_o(wr_addr), .ptr_o(wr_ptr_q)
    );

    smf_ptr #(.DEPTH(DEPTH)) u_rd_ptr (
        .clk_i (clk_i), .rst_ni(rst_ni),
        .clr_i (rd_rst_i), .step_i(rd_en_i),
        .addr_o(rd_addr), .ptr_o(rd_ptr_q)
    );

    smf_commit_line #(.DEPTH(DEPTH), .COMMIT_LAT(COMMIT_LAT)) u_line (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .in_vld_i  (wr_en_i),
        .in_addr_i (wr_addr),
        .in_data_i (wr_data_i),
        .out_vld_o (cm_vld),
        .out_addr_o(cm_addr),
        .out_data_o(cm_data)
    );

    smf_store #(.DEPTH(DEPTH)) u_store (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .we_i   (cm_vld),
        .waddr_i(cm_addr),
        .wdata_i(cm_data),
        .re_i   (rd_en_i),
        .raddr_i(rd_addr),
        .rdata_o(rd_data_o),
        .rvld_o (rd_valid_o)
    );
endmodule

module smf_field_mem_chk #(
    parameter int unsigned DEPTH = 256,
    localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input logic          clk_i,
    input logic          rst_ni,
    input logic          wr_en_i,
    input logic          wr_rst_i,
    input logic          rd_en_i,
    input logic          rd_rst_i,
    input logic          rd_valid_o,
    input logic [11:0]   rd_data_o,
    input logic [AW-1:0] wr_ptr,
    input logic [AW-1:0] rd_ptr
);
    p_rd_valid_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd_en_i |=> rd_valid_o);
    p_rd_idle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rd_en_i |=> (!rd_valid_o && $stable(rd_data_o)));
    p_wr_restart_wr_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_rst_i && wr_en_i) |=> (wr_ptr == AW'(1)));
    p_wr_restart_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_rst_i && !wr_en_i) |=> (wr_ptr == '0));
    p_wr_wrap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && !wr_rst_i && wr_ptr == AW'(DEPTH - 1)) |=> (wr_ptr == '0));
    p_rd_restart_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_rst_i && !rd_en_i) |=> (rd_ptr == '0));
    p_wr_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!wr_en_i && !wr_rst_i) |=> $stable(wr_ptr));
    p_rd_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!rd_en_i && !rd_rst_i) |=> $stable(rd_ptr));
endmodule

bind smf_field_mem smf_field_mem_chk #(.DEPTH(DEPTH)) u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_rst_i  (wr_rst_i),
    .rd_en_i   (rd_en_i),
    .rd_rst_i  (rd_rst_i),
    .rd_valid_o(rd_valid_o),
    .rd_data_o (rd_data_o),
    .wr_ptr    (wr_ptr_q),
    .rd_ptr    (rd_ptr_q)
);

// File: tb/smf_field_mem_tb.sv
module smf_field_mem_tb_top;
    localparam int DEPTH = 16;
    localparam int LAT   = 24;
    localparam int OWIN  = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, wr_rst = 1'b0, rd_en = 1'b0, rd_rst = 1'b0;
    logic [11:0] wr_data = '0;
    logic [11:0] rd_data;
    logic        rd_valid;

    int    n_tests = 0;
    int    n_fail  = 0;
    bit    done    = 1'b0;
    string cur_req = "R1";
    logic [11:0] exp_q[$];
    logic [11:0] shadow [DEPTH];

    always #4 clk = ~clk;

    smf_field_mem #(.DEPTH(DEPTH), .COMMIT_LAT(LAT), .OLD_WIN(OWIN)) dut_i (
        .clk_i(clk), .rst_ni(rst_n),
        .wr_en_i(wr_en), .wr_data_i(wr_data), .wr_rst_i(wr_rst),
        .rd_en_i(rd_en), .rd_rst_i(rd_rst),
        .rd_data_o(rd_data), .rd_valid_o(rd_valid)
    );

    function automatic logic [11:0] pat(int f, int i);
        return 12'((f * 389 + i * 37 + 11) & 32'hFFF);
    endfunction

    task automatic check(bit ok, string req, logic [11:0] act, logic [11:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one cycle; a read pushes its expected word to the scoreboard.
    task automatic tick(bit we, logic [11:0] wd, bit wrst, bit re, bit rrst,
                        logic [11:0] exp);
        @(negedge clk);
        wr_en = we; wr_data = wd; wr_rst = wrst;
        rd_en = re; rd_rst = rrst;
        if (re) exp_q.push_back(exp);
    endtask

    task automatic idle(int n);
        for (int k = 0; k < n; k++) tick(0, '0, 0, 0, 0, '0);
    endtask

    // Writer and reader in lockstep; reader restarts `lag` cycles after writer.
    task automatic overlap(int lag, int f, bit want_new, string req);
        cur_req = req;
        for (int c = 0; c < lag + DEPTH; c++) begin
            int i;
            i = c - lag;
            tick(c < DEPTH, pat(f, c), c == 0, c >= lag, c == lag,
                 (i < 0) ? 12'h0 : (want_new ? pat(f, i) : shadow[i]));
        end
        idle(LAT + 2);
        for (int i = 0; i < DEPTH; i++) shadow[i] = pat(f, i);
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, {cur_req, " unexpected valid"}, rd_data, 12'h0);
            end else begin
                logic [11:0] e;
                e = exp_q.pop_front();
                check(rd_data === e, cur_req, rd_data, e);
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog (%s) actual=hung expected=finished", cur_req);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(rd_valid == 1'b0, "R1 valid in reset", {11'h0, rd_valid}, 12'h0);
        check(rd_data == 12'h0, "R1 data in reset", rd_data, 12'h0);
        rst_n = 1'b1;
        idle(2);
        check(rd_valid == 1'b0, "R1 valid after reset", {11'h0, rd_valid}, 12'h0);
        check(rd_data == 12'h0, "R1 data after reset", rd_data, 12'h0);

        // R2 sequential write of a full field, then R4 straight readback
        cur_req = "R2";
        for (int i = 0; i < DEPTH; i++) tick(1, pat(1, i), i == 0, 0, 0, '0);
        for (int i = 0; i < DEPTH; i++) shadow[i] = pat(1, i);
        idle(LAT + 2);
        cur_req = "R4";
        for (int i = 0; i < DEPTH; i++) tick(0, '0, 0, 1, i == 0, shadow[i]);
        idle(3);

        // Restart-distance sweep
        overlap(0,        2, 1'b0, "R6 lag0");
        overlap(OWIN,     3, 1'b0, "R6 lagOWIN");
        overlap(LAT - 1,  4, 1'b0, "R5 lagLAT-1");
        overlap(LAT,      5, 1'b1, "R5 lagLAT");
        overlap(LAT + 9,  6, 1'b1, "R7 lagLong");

        // R2 write wrap: two extra words land on addresses 0 and 1
        cur_req = "R2 wrap";
        for (int c = 0; c < DEPTH + 2; c++)
            tick(1, (c < DEPTH) ? pat(7, c) : pat(8, c - DEPTH), c == 0, 0, 0, '0);
        for (int i = 0; i < DEPTH; i++) shadow[i] = pat(7, i);
        shadow[0] = pat(8, 0);
        shadow[1] = pat(8, 1);
        idle(LAT + 2);
        cur_req = "R3 wrap";
        for (int c = 0; c < DEPTH + 2; c++)
            tick(0, '0, 0, 1, c == 0, shadow[c % DEPTH]);
        idle(3);

        // R4/R3: idle output hold, restart without read
        cur_req = "R3 gap";
        for (int c = 0; c < 3; c++) tick(0, '0, 0, 1, c == 0, shadow[c]);
        idle(1);
        tick(0, '0, 0, 0, 1, '0);
        check(rd_valid == 1'b0, "R4 idle valid", {11'h0, rd_valid}, 12'h0);
        check(rd_data == shadow[2], "R4 idle hold", rd_data, shadow[2]);
        tick(0, '0, 0, 1, 0, shadow[0]);
        check(rd_valid == 1'b0, "R3 restart-only no output", {11'h0, rd_valid}, 12'h0);
        check(rd_data == shadow[2], "R3 restart-only hold", rd_data, shadow[2]);
        tick(0, '0, 0, 1, 0, shadow[1]);
        idle(3);

        // R8: write restart alone, then writes with an idle cycle between
        cur_req = "R8";
        tick(0, '0, 1, 0, 0, '0);
        tick(1, pat(9, 0), 0, 0, 0, '0);
        idle(1);
        tick(1, pat(9, 1), 0, 0, 0, '0);
        shadow[0] = pat(9, 0);
        shadow[1] = pat(9, 1);
        idle(LAT + 2);
        for (int c = 0; c < 3; c++) tick(0, '0, 0, 1, c == 0, shadow[c]);
        idle(4);
        check(exp_q.size() == 0, "R4 all reads returned", 12'(exp_q.size()), 12'h0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule